// File: doc/BRIEF.md
# Seconds Real-Time Counter with Alarm

This block keeps wall-clock time as one long binary count. A strobe marks each period of a 32.768 kHz low-power tick. The count is split into a whole-seconds word (`SEC_W` bits, 32 by default) and a sub-second fraction (`FRAC_W` bits, 15 by default), so the fraction wraps once per second. The block compares the seconds word with a programmable alarm word. When the two meet, it sets a sticky alarm flag, and that flag drives an interrupt line through an enable bit.

Software reaches the block through a single-cycle write port with a 3-bit select. Select 0 writes the seconds word, 1 the fraction, 2 the alarm, 3 the control word and 4 the write-one-to-clear status. The count advances only when all of these hold: the enable bit is set, the overflow flag is clear, the not-valid flag is clear, and an external security monitor is not in its failure state. Freezing the count on a failure preserves the time at which the violation happened. After a power-up or a recovery, writing the seconds word re-arms the count. A wrap past the largest value sets the overflow flag. If overflow tamper is enabled, the block also asks the monitor to enter its failure state.

Top module: `rtc_seconds_counter`

## Requirements
- R1: After reset the seconds and fraction words are 0, the alarm word is all ones, the control word is 0, the not-valid flag is 1, the alarm and overflow flags are 0, and `irq_o` is 0.
- R2: Each accepted tick adds one to the combined {seconds, fraction} value. The fraction rolls from all ones to 0 and carries into seconds on the same edge.
- R3: A tick is accepted only while control bit 0 (count enable) is 1, the overflow flag is 0 and the not-valid flag is 0. Otherwise seconds and fraction hold.
- R4: While `fail_i` is high, seconds and fraction hold, and writes to select 0 and select 1 are refused.
- R5: A write to select 0 loads seconds, clears the not-valid flag and leaves the fraction untouched. A write to select 1 loads the fraction from the low `FRAC_W` data bits and leaves seconds untouched. Either write takes precedence over a tick in the same cycle.
- R6: Control bit 3 (soft lock) and bit 4 (hard lock) can only be set by writing 1 and are cleared only by reset. While either is set, writes to selects 0 and 1 are refused. While the hard lock is set, a control write cannot change bit 0.
- R7: The alarm flag sets on the edge where an accepted tick carries seconds into a value equal to the alarm word. A seconds or alarm write that makes the two equal does not set it.
- R8: The alarm flag stays set until a write to select 4 with data bit 0 equal to 1. A match in the same cycle as that clear wins.
- R9: `irq_o` is high exactly while the alarm flag is 1, control bit 1 (alarm interrupt enable) is 1 and `svc_i` is 0.
- R10: A tick that wraps {seconds, fraction} from all ones to 0 sets the overflow flag, which then halts counting.
- R11: `fail_req_o` is high exactly while the overflow flag is 1 and control bit 2 (overflow tamper enable) is 1.
- R12: A write to select 4 clears the overflow flag when data bit 1 is 1 and clears the not-valid flag when data bit 2 is 1. Zero bits leave the flags unchanged, and a wrap in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per low-power tick period |
| fail_i | input | 1 | Security monitor is in its failure state |
| svc_i | input | 1 | Alarm interrupt is being serviced; masks `irq_o` |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status clear |
| wr_data_i | input | SEC_W | Write data |
| seconds_o | output | SEC_W | Whole-seconds word |
| frac_o | output | FRAC_W | Sub-second fraction |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| ovf_flag_o | output | 1 | Counter wrapped |
| invalid_o | output | 1 | Time not valid; counting held |
| irq_o | output | 1 | Alarm interrupt |
| fail_req_o | output | 1 | Overflow request to the security monitor |

## Verification
Every write and every accepted tick shows up at the registered outputs on the first clock edge after it is presented: seconds, fraction and the three flags each move exactly one edge later. `irq_o` and `fail_req_o` are combinational from those flags and from `svc_i`, so they follow in the same cycle. The bench drives each stimulus just after a falling edge, advances its behavioural reference on the rising edge that consumes that stimulus, and compares every output at the next falling edge. Each comparison therefore falls exactly one register stage after its cause, and directed checks at the same points pin down literal values for alarm hits, wraps, refused writes and lock behaviour.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int SEL_W  = 3;
    localparam int CTRL_W = 5;

    localparam int STAT_ALARM_BIT = 0;
    localparam int STAT_OVF_BIT   = 1;
    localparam int STAT_NV_BIT    = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_FRAC  = 3'd1,
        SEL_ALARM = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_STAT  = 3'd4
    } reg_sel_e;

    // bit 4 hard lock, bit 3 soft lock, bit 2 overflow tamper, bit 1 alarm ie, bit 0 enable
    typedef struct packed {
        logic hard_lock;
        logic soft_lock;
        logic ovf_tamper;
        logic alarm_ie;
        logic cnt_en;
    } ctrl_t;

    // Lock bits are set-only; the hard lock pins the enable bit.
    function automatic ctrl_t ctrl_next(input ctrl_t cur, input logic [CTRL_W-1:0] wd);
        ctrl_t req;
        ctrl_t nxt;
        req            = ctrl_t'(wd);
        nxt.cnt_en     = cur.hard_lock ? cur.cnt_en : req.cnt_en;
        nxt.alarm_ie   = req.alarm_ie;
        nxt.ovf_tamper = req.ovf_tamper;
        nxt.soft_lock  = cur.soft_lock | req.soft_lock;
        nxt.hard_lock  = cur.hard_lock | req.hard_lock;
        return nxt;
    endfunction

    function automatic logic counter_writable(input ctrl_t c, input logic fail);
        return !(c.soft_lock || c.hard_lock || fail);
    endfunction

endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
    import rtc_sec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              alarm_we,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] alarm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            alarm_q <= '1;
        end else begin
            if (ctrl_we) begin
                ctrl_q <= ctrl_next(ctrl_q, wr_data[CTRL_W-1:0]);
            end
            if (alarm_we) begin
                alarm_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              sec_we,
    input  logic              frac_we,
    input  logic [SEC_W-1:0]  wr_data,
    input  logic              clr_ovf,
    input  logic              clr_nv,
    output logic [SEC_W-1:0]  sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              ovf_q,
    output logic              nv_q,
    output logic              sec_step,
    output logic [SEC_W-1:0]  sec_inc
);

    localparam int TOT_W = SEC_W + FRAC_W;

    logic [TOT_W:0] sum;
    logic           wrap;

    assign sum      = {1'b0, sec_q, frac_q} + {{TOT_W{1'b0}}, 1'b1};
    assign wrap     = run && sum[TOT_W];
    assign sec_step = run && (frac_q == {FRAC_W{1'b1}});
    assign sec_inc  = sum[TOT_W-1:FRAC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q  <= '0;
            frac_q <= '0;
            ovf_q  <= 1'b0;
            nv_q   <= 1'b1;
        end else begin
            if (sec_we) begin
                sec_q <= wr_data;
            end else if (sec_step) begin
                sec_q <= sec_inc;
            end

            if (frac_we) begin
                frac_q <= wr_data[FRAC_W-1:0];
            end else if (run) begin
                frac_q <= sum[FRAC_W-1:0];
            end

            if (wrap) begin
                ovf_q <= 1'b1;
            end else if (clr_ovf) begin
                ovf_q <= 1'b0;
            end

            if (sec_we || clr_nv) begin
                nv_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_step,
    input  logic [SEC_W-1:0] sec_inc,
    input  logic [SEC_W-1:0] alarm,
    input  logic             clr,
    input  logic             irq_en,
    input  logic             svc,
    output logic             flag_q,
    output logic             irq
);

    logic hit;

    assign hit = sec_step && (sec_inc == alarm);
    assign irq = flag_q && irq_en && !svc;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter
    import rtc_sec_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              fail_i,
    input  logic              svc_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [SEC_W-1:0]  wr_data_i,
    output logic [SEC_W-1:0]  seconds_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              alarm_flag_o,
    output logic              ovf_flag_o,
    output logic              invalid_o,
    output logic              irq_o,
    output logic              fail_req_o
);

    ctrl_t            ctrl_q;
    logic [SEC_W-1:0] alarm_q;
    logic             writable;
    logic             sec_we;
    logic             frac_we;
    logic             ctrl_we;
    logic             alarm_we;
    logic             stat_we;
    logic             run;
    logic             sec_step;
    logic [SEC_W-1:0] sec_inc;

    assign writable = counter_writable(ctrl_q, fail_i);
    assign sec_we   = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_SEC)  && writable;
    assign frac_we  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FRAC) && writable;
    assign alarm_we = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_ALARM);
    assign ctrl_we  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
    assign stat_we  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STAT);

    assign run = tick_i && ctrl_q.cnt_en && !ovf_flag_o && !invalid_o && !fail_i;

    assign fail_req_o = ovf_flag_o && ctrl_q.ovf_tamper;

    rtc_cfg_regs #(.DATA_W(SEC_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .alarm_we (alarm_we),
        .wr_data  (wr_data_i),
        .ctrl_q   (ctrl_q),
        .alarm_q  (alarm_q)
    );

    rtc_time_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sec_we   (sec_we),
        .frac_we  (frac_we),
        .wr_data  (wr_data_i),
        .clr_ovf  (stat_we && wr_data_i[STAT_OVF_BIT]),
        .clr_nv   (stat_we && wr_data_i[STAT_NV_BIT]),
        .sec_q    (seconds_o),
        .frac_q   (frac_o),
        .ovf_q    (ovf_flag_o),
        .nv_q     (invalid_o),
        .sec_step (sec_step),
        .sec_inc  (sec_inc)
    );

    rtc_alarm_match #(.SEC_W(SEC_W)) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .sec_step (sec_step),
        .sec_inc  (sec_inc),
        .alarm    (alarm_q),
        .clr      (stat_we && wr_data_i[STAT_ALARM_BIT]),
        .irq_en   (ctrl_q.alarm_ie),
        .svc      (svc_i),
        .flag_q   (alarm_flag_o),
        .irq      (irq_o)
    );

endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk
    import rtc_sec_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              fail_i,
    input logic              svc_i,
    input logic              run,
    input logic              sec_we,
    input logic              frac_we,
    input ctrl_t             ctrl_q,
    input logic [SEC_W-1:0]  alarm_q,
    input logic [SEC_W-1:0]  seconds_o,
    input logic [FRAC_W-1:0] frac_o,
    input logic              alarm_flag_o,
    input logic              ovf_flag_o,
    input logic              irq_o
);

    assert_frozen_on_fail_R4: assert property (@(posedge clk) disable iff (rst)
        fail_i |=> ($stable(seconds_o) && $stable(frac_o)));

    assert_sec_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !sec_we) |=> $stable(seconds_o));

    assert_frac_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !frac_we) |=> $stable(frac_o));

    assert_wrap_to_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovf_flag_o) && !$past(sec_we) && !$past(frac_we)) |->
            (seconds_o == '0 && frac_o == '0));

    assert_alarm_match_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(alarm_flag_o) && !$past(sec_we)) |-> (seconds_o == alarm_q));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (svc_i || !alarm_flag_o) |-> !irq_o);

    assert_hard_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hard_lock |=> ctrl_q.hard_lock);

    assert_soft_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.soft_lock |=> ctrl_q.soft_lock);

endmodule

bind rtc_seconds_counter rtc_seconds_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fail_i       (fail_i),
    .svc_i        (svc_i),
    .run          (run),
    .sec_we       (sec_we),
    .frac_we      (frac_we),
    .ctrl_q       (ctrl_q),
    .alarm_q      (alarm_q),
    .seconds_o    (seconds_o),
    .frac_o       (frac_o),
    .alarm_flag_o (alarm_flag_o),
    .ovf_flag_o   (ovf_flag_o),
    .irq_o        (irq_o)
);

// File: tb/rtc_seconds_counter_tb.sv
module rtc_seconds_counter_tb;

    localparam int SW = 32;
    localparam int FW = 2;
    localparam longint unsigned FMAX = (64'd1 << FW) - 1;
    localparam longint unsigned SMAX = (64'd1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic          fail_i = 1'b0;
    logic          svc_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [2:0]    wr_sel_i = 3'd0;
    logic [SW-1:0] wr_data_i = '0;
    logic [SW-1:0] seconds_o;
    logic [FW-1:0] frac_o;
    logic          alarm_flag_o, ovf_flag_o, invalid_o, irq_o, fail_req_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rtc_seconds_counter #(.SEC_W(SW), .FRAC_W(FW)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .fail_i(fail_i), .svc_i(svc_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .seconds_o(seconds_o), .frac_o(frac_o), .alarm_flag_o(alarm_flag_o),
        .ovf_flag_o(ovf_flag_o), .invalid_o(invalid_o), .irq_o(irq_o),
        .fail_req_o(fail_req_o)
    );

    // Behavioural reference model
    longint unsigned m_sec, m_frac, m_alarm;
    bit m_en, m_ie, m_ote, m_sl, m_hl, m_af, m_ovf, m_nv;

    always @(posedge clk) begin
        longint unsigned n_sec, n_frac, cnt_sec;
        bit run, step, wrapped, wok;
        if (rst) begin
            m_sec = 0; m_frac = 0; m_alarm = SMAX;
            m_en = 0; m_ie = 0; m_ote = 0; m_sl = 0; m_hl = 0;
            m_af = 0; m_ovf = 0; m_nv = 1;
        end else begin
            wok = !fail_i && !m_sl && !m_hl;
            run = tick_i && m_en && !m_ovf && !m_nv && !fail_i;
            n_sec = m_sec; n_frac = m_frac; cnt_sec = m_sec; step = 0; wrapped = 0;
            if (run) begin
                if (m_frac == FMAX) begin
                    n_frac = 0; step = 1;
                    if (m_sec == SMAX) begin cnt_sec = 0; wrapped = 1; end
                    else cnt_sec = m_sec + 1;
                    n_sec = cnt_sec;
                end else n_frac = m_frac + 1;
            end
            if (wr_en_i && wr_sel_i == 3'd4) begin
                if (wr_data_i[0]) m_af = 0;
                if (wr_data_i[1]) m_ovf = 0;
                if (wr_data_i[2]) m_nv = 0;
            end
            if (step && cnt_sec == m_alarm) m_af = 1;
            if (wrapped) m_ovf = 1;
            if (wr_en_i && wr_sel_i == 3'd0 && wok) begin n_sec = wr_data_i; m_nv = 0; end
            if (wr_en_i && wr_sel_i == 3'd1 && wok) n_frac = wr_data_i & FMAX;
            if (wr_en_i && wr_sel_i == 3'd2) m_alarm = wr_data_i;
            if (wr_en_i && wr_sel_i == 3'd3) begin
                if (!m_hl) m_en = wr_data_i[0];
                m_ie = wr_data_i[1]; m_ote = wr_data_i[2];
                m_sl = m_sl | wr_data_i[3]; m_hl = m_hl | wr_data_i[4];
            end
            m_sec = n_sec; m_frac = n_frac;
        end
    end

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) begin
            chk("R2 seconds", seconds_o, m_sec);
            chk("R2 fraction", frac_o, m_frac);
            chk("R8 alarm flag", alarm_flag_o, m_af);
            chk("R10 overflow flag", ovf_flag_o, m_ovf);
            chk("R12 not-valid flag", invalid_o, m_nv);
            chk("R9 irq", irq_o, m_af && m_ie && !svc_i);
            chk("R11 fail request", fail_req_o, m_ovf && m_ote);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [SW-1:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        longint unsigned keep_s, keep_f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        chk("R1 seconds", seconds_o, 0);
        chk("R1 fraction", frac_o, 0);
        chk("R1 not-valid", invalid_o, 1);
        chk("R1 alarm flag", alarm_flag_o, 0);
        chk("R1 overflow", ovf_flag_o, 0);
        chk("R1 irq", irq_o, 0);

        tick_i = 1'b1;
        wr(3'd3, 32'd1);
        idle(5);
        chk("R3 held by not-valid", {seconds_o, frac_o}, 0);
        wr(3'd4, 32'd0);
        chk("R12 zero clear keeps not-valid", invalid_o, 1);
        wr(3'd4, 32'd4);
        chk("R12 not-valid cleared", invalid_o, 0);
        idle(6);
        chk("R2 counting", seconds_o, 1);

        tick_i = 1'b0;
        keep_f = frac_o;
        wr(3'd0, 32'd100);
        chk("R5 seconds loaded", seconds_o, 100);
        chk("R5 fraction kept", frac_o, keep_f);
        wr(3'd1, 32'd3);
        chk("R5 fraction loaded", frac_o, 3);
        chk("R5 seconds kept", seconds_o, 100);

        wr(3'd2, 32'd100);
        chk("R7 write-equal no flag", alarm_flag_o, 0);
        wr(3'd2, 32'd102);
        wr(3'd3, 32'd3);
        tick_i = 1'b1;
        idle(8);
        chk("R7 alarm hit", alarm_flag_o, 1);
        chk("R9 irq raised", irq_o, 1);
        svc_i = 1'b1;
        step();
        chk("R9 irq masked by service", irq_o, 0);
        svc_i = 1'b0;
        idle(8);
        chk("R8 flag sticky", alarm_flag_o, 1);
        wr(3'd4, 32'd1);
        chk("R8 flag cleared", alarm_flag_o, 0);
        chk("R9 irq low after clear", irq_o, 0);

        wr(3'd3, 32'd2);
        keep_s = seconds_o; keep_f = frac_o;
        idle(5);
        chk("R3 hold when disabled", {seconds_o, frac_o}, {keep_s[SW-1:0], keep_f[FW-1:0]});

        wr(3'd3, 32'd3);
        fail_i = 1'b1;
        keep_s = seconds_o; keep_f = frac_o;
        idle(4);
        wr(3'd0, 32'd5);
        chk("R4 frozen seconds", seconds_o, keep_s);
        chk("R4 frozen fraction", frac_o, keep_f);
        fail_i = 1'b0;

        tick_i = 1'b0;
        wr(3'd3, 32'd7);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'd2);
        tick_i = 1'b1;
        idle(4);
        chk("R10 overflow set", ovf_flag_o, 1);
        chk("R10 wrapped seconds", seconds_o, 0);
        chk("R11 fail request", fail_req_o, 1);
        idle(3);
        chk("R10 halted fraction", frac_o, 0);
        wr(3'd4, 32'd2);
        chk("R12 overflow cleared", ovf_flag_o, 0);
        chk("R11 request dropped", fail_req_o, 0);

        tick_i = 1'b0;
        wr(3'd3, 32'd9);
        keep_s = seconds_o;
        wr(3'd0, 32'd55);
        chk("R6 soft lock refuses write", seconds_o, keep_s);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd66);
        chk("R6 soft lock sticky", seconds_o, keep_s);
        wr(3'd3, 32'd17);
        wr(3'd3, 32'd0);
        keep_f = frac_o;
        tick_i = 1'b1;
        idle(2);
        chk("R6 hard lock pins enable", frac_o != keep_f[FW-1:0], 1);
        idle(3);
        summary();
    end

endmodule